// File: doc/BRIEF.md
# Generation-Bit Event Queue Writer

This block is the producing end of an event queue that lives in ordinary memory. Interrupt sources hand it notifications, each carrying a 31-bit interrupt number. The block turns each notification into a 32-bit entry and writes it into a ring whose size is a power of two, using a plain single-port write interface. The producer and the consumer exchange no head or tail pointers. Instead, the top bit of every entry is a generation bit. Its polarity inverts each time the producer's write index wraps to the start of the ring. A consumer that keeps a matching toggle of its own can therefore tell fresh entries from stale ones.

The ring is taken to start zero-filled. The first pass through it writes generation 1, so a consumer whose toggle starts at 0 sees every first-pass entry as new. Interrupt number zero is never written, because a zero word reads as "nothing here". A separate request input posts an inter-processor interrupt. It is encoded as the reserved number one step beyond a 24-bit source space, and it wins over a device notification arriving in the same cycle.

The consumer reports its read position through an index and toggle pair. When a write would land on an entry the consumer has not yet taken, the notification is discarded and a sticky overflow flag is raised. A notify pulse follows every write into the ring.

Top module: `evq_producer`

## Requirements
- R1: After a synchronous reset the write index is 0, the generation is 1, no memory write or notify is presented, and the overflow flag is 0.
- R2: A device notification is accepted in a cycle where both `ntf_valid` and `ntf_ready` are high. In the following cycle `mem_we` is high for exactly one cycle, with `mem_addr` equal to the write index at acceptance and `mem_wdata` equal to {generation (bit 31), number (bits 30:0)}.
- R3: Each entry written advances the write index by one, modulo 2^LOG2_ENTRIES.
- R4: The generation inverts in the same cycle that the write index wraps from its last value to 0. Entries written on the first pass after reset carry generation 1.
- R5: A request whose number is 0 is accepted and discarded. It produces no write, leaves the index and generation unchanged, and does not set the overflow flag.
- R6: While `ipi_req` is high, `ntf_ready` is low and the entry written carries number 0x0100_0000 (only bit 24 set). `ntf_ready` is also low during reset.
- R7: The ring is full when the write index equals `cons_idx` and the generation equals `cons_tgl`. A non-zero request that arrives while the ring is full is discarded without a write, and the overflow flag is set in the next cycle.
- R8: Once set, the overflow flag stays set until reset.
- R9: `notify` is high for one cycle in the cycle after each memory write, and at no other time.
- R10: A consumer that follows the toggle rule reads the non-dropped numbers back in the order they were accepted, including across several wraps of the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_valid | input | 1 | Device notification offered |
| ntf_ready | output | 1 | Notification can be taken this cycle |
| ntf_num | input | 31 | Interrupt number of the notification |
| ipi_req | input | 1 | Post an inter-processor interrupt this cycle |
| cons_idx | input | LOG2_ENTRIES | Consumer's next read index |
| cons_tgl | input | 1 | Consumer's current toggle |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | LOG2_ENTRIES | Ring memory entry address |
| mem_wdata | output | 32 | Entry: generation in bit 31, number in bits 30:0 |
| wr_idx | output | LOG2_ENTRIES | Producer write index |
| wr_gen | output | 1 | Generation used for the next entry |
| notify | output | 1 | Pulse after each ring write |
| overflow | output | 1 | Sticky: a request was dropped on a full ring |

## Verification
The hardest condition to reach from the ports is a truly full ring. It needs the producer to lap a stalled consumer, so that the index matches and the generation equals the consumer's toggle rather than its opposite. The bench holds its consumer idle while it writes enough entries to fill the eight-entry ring, then keeps sending to force drops. After that it releases the consumer and streams traffic through several wraps, so that both generation values and the empty-versus-full distinction at equal indices are exercised.

// File: rtl/evq_pkg.sv
package evq_pkg;

    localparam int NUM_W    = 31;
    localparam int ENTRY_W  = NUM_W + 1;
    localparam int SRC_BITS = 24;

    typedef logic [NUM_W-1:0] num_t;

    // reserved inter-processor number: first value past the source space
    localparam num_t IPI_NUM = num_t'(1) << SRC_BITS;

    typedef struct packed {
        logic gen;
        num_t num;
    } entry_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_DEVICE = 2'd1,
        SRC_IPI    = 2'd2
    } src_e;

    typedef struct packed {
        src_e src;
        num_t num;
    } req_t;

    function automatic entry_t make_entry(input logic gen, input num_t n);
        entry_t e;
        e.gen = gen;
        e.num = n;
        return e;
    endfunction

    // a request may enter the ring only if present and non-zero
    function automatic logic req_usable(input req_t r);
        return (r.src != SRC_NONE) && (r.num != '0);
    endfunction

endpackage

// File: rtl/evq_req_arb.sv
module evq_req_arb
    import evq_pkg::*;
(
    input  logic rst,
    input  logic ntf_valid,
    input  num_t ntf_num,
    input  logic ipi_req,
    output logic ntf_ready,
    output req_t req
);

    always_comb begin
        req.src   = SRC_NONE;
        req.num   = '0;
        ntf_ready = 1'b0;
        if (!rst) begin
            if (ipi_req) begin
                req.src = SRC_IPI;
                req.num = IPI_NUM;
            end else begin
                ntf_ready = 1'b1;
                if (ntf_valid) begin
                    req.src = SRC_DEVICE;
                    req.num = ntf_num;
                end
            end
        end
    end

endmodule

// File: rtl/evq_ring_ptr.sv
module evq_ring_ptr #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [IDX_W-1:0] cons_idx,
    input  logic             cons_tgl,
    output logic [IDX_W-1:0] idx,
    output logic             gen,
    output logic             full
);

    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    logic [IDX_W-1:0] idx_q;
    logic             gen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            gen_q <= 1'b1;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) begin
                gen_q <= ~gen_q;
            end
        end
    end

    // equal positions: empty if the consumer expects our generation,
    // full if the producer has lapped it (generation equals its toggle)
    assign full = (idx_q == cons_idx) && (gen_q == cons_tgl);
    assign idx  = idx_q;
    assign gen  = gen_q;

    AST_NO_ADVANCE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        full |-> !advance);  // R7

endmodule

// File: rtl/evq_write_stage.sv
module evq_write_stage
    import evq_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic             drop,
    input  logic [IDX_W-1:0] addr,
    input  entry_t           entry,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_addr,
    output entry_t           mem_entry,
    output logic             notify,
    output logic             overflow
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_entry <= '0;
            notify    <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            mem_we <= commit;
            notify <= mem_we;
            if (commit) begin
                mem_addr  <= addr;
                mem_entry <= entry;
            end
            if (drop) begin
                overflow <= 1'b1;
            end
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);  // R8

    AST_NONZERO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_entry.num != '0));  // R5

endmodule

// File: rtl/evq_producer.sv
module evq_producer
    import evq_pkg::*;
#(
    parameter int LOG2_ENTRIES = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ntf_valid,
    output logic                    ntf_ready,
    input  logic [NUM_W-1:0]        ntf_num,
    input  logic                    ipi_req,
    input  logic [LOG2_ENTRIES-1:0] cons_idx,
    input  logic                    cons_tgl,
    output logic                    mem_we,
    output logic [LOG2_ENTRIES-1:0] mem_addr,
    output logic [ENTRY_W-1:0]      mem_wdata,
    output logic [LOG2_ENTRIES-1:0] wr_idx,
    output logic                    wr_gen,
    output logic                    notify,
    output logic                    overflow
);

    localparam int IDX_W = LOG2_ENTRIES;
    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    req_t       req;
    logic       usable;
    logic       full;
    logic       commit;
    logic       drop;
    entry_t     new_entry;
    entry_t     out_entry;
    logic [IDX_W-1:0] idx;
    logic       gen;

    evq_req_arb u_arb (
        .rst       (rst),
        .ntf_valid (ntf_valid),
        .ntf_num   (ntf_num),
        .ipi_req   (ipi_req),
        .ntf_ready (ntf_ready),
        .req       (req)
    );

    evq_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .advance  (commit),
        .cons_idx (cons_idx),
        .cons_tgl (cons_tgl),
        .idx      (idx),
        .gen      (gen),
        .full     (full)
    );

    assign usable    = req_usable(req);
    assign commit    = usable && !full;
    assign drop      = usable && full;
    assign new_entry = make_entry(gen, req.num);

    evq_write_stage #(.IDX_W(IDX_W)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .drop      (drop),
        .addr      (idx),
        .entry     (new_entry),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_entry (out_entry),
        .notify    (notify),
        .overflow  (overflow)
    );

    assign mem_wdata = out_entry;
    assign wr_idx    = idx;
    assign wr_gen    = gen;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (wr_idx == IDX_W'(mem_addr + 1'b1)));  // R3

    AST_GEN_KEPT: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr != LAST_IDX) |-> (out_entry.gen == wr_gen));  // R4

    AST_GEN_FLIP: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr == LAST_IDX) |-> (out_entry.gen != wr_gen));  // R4

    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (usable && full) |=> (!mem_we && overflow));  // R7

    AST_NOTIFY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> notify);  // R9

endmodule

// File: tb/evq_producer_bench.sv
module evq_producer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LOG2 = 3;
    localparam int N = 1 << LOG2;
    localparam logic [30:0] IPI_VAL = 31'h0100_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ntf_valid = 1'b0;
    logic ntf_ready;
    logic [30:0] ntf_num = '0;
    logic ipi_req = 1'b0;
    logic [LOG2-1:0] cons_idx;
    logic cons_tgl;
    logic mem_we;
    logic [LOG2-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [LOG2-1:0] wr_idx;
    logic wr_gen;
    logic notify;
    logic overflow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evq_producer #(.LOG2_ENTRIES(LOG2)) u_evq_producer (
        .clk(clk), .rst(rst), .ntf_valid(ntf_valid), .ntf_ready(ntf_ready),
        .ntf_num(ntf_num), .ipi_req(ipi_req), .cons_idx(cons_idx),
        .cons_tgl(cons_tgl), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wr_idx(wr_idx), .wr_gen(wr_gen),
        .notify(notify), .overflow(overflow)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at t=%0t", what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_idx = 0;
    int          m_gen = 1;
    logic        m_we = 0;
    int          m_addr = 0;
    logic [31:0] m_data = '0;
    logic        m_notify = 0;
    logic        m_ovf = 0;
    logic [30:0] expq[$];

    always @(posedge clk) begin
        if (rst) begin
            m_idx = 0; m_gen = 1; m_we = 0; m_addr = 0; m_data = '0;
            m_notify = 0; m_ovf = 0; expq.delete();
        end else begin
            logic has;
            logic [30:0] num;
            m_notify = m_we;
            m_we = 0;
            has = 0; num = '0;
            if (ipi_req) begin has = 1; num = IPI_VAL; end
            else if (ntf_valid) begin has = 1; num = ntf_num; end
            if (has && num != 0) begin
                if (m_idx == int'(cons_idx) && m_gen == int'(cons_tgl)) begin
                    m_ovf = 1;
                end else begin
                    m_we = 1;
                    m_addr = m_idx;
                    m_data = {m_gen[0], num};
                    expq.push_back(num);
                    m_idx = (m_idx + 1) % N;
                    if (m_idx == 0) m_gen = 1 - m_gen;
                end
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        check("R2 mem_we", {31'd0, mem_we}, {31'd0, m_we});
        if (m_we) begin
            check("R2 mem_addr", 32'(mem_addr), 32'(m_addr));
            check("R2 mem_wdata", mem_wdata, m_data);
        end
        check("R3 wr_idx", 32'(wr_idx), 32'(m_idx));
        check("R4 wr_gen", {31'd0, wr_gen}, 32'(m_gen));
        check("R9 notify", {31'd0, notify}, {31'd0, m_notify});
        check("R7 overflow", {31'd0, overflow}, {31'd0, m_ovf});
        check("R6 ntf_ready", {31'd0, ntf_ready}, {31'd0, (!rst && !ipi_req)});
    end

    // ---------------- ring memory and consumer ----------------
    logic [31:0] bmem [N];
    logic [LOG2-1:0] cidx = '0;
    logic ctgl = 1'b0;
    logic cons_en = 1'b0;
    assign cons_idx = cidx;
    assign cons_tgl = ctgl;

    initial begin
        for (int i = 0; i < N; i++) bmem[i] = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) bmem[i] = '0;
        end else if (mem_we) begin
            bmem[mem_addr] = mem_wdata;
        end
        #1;
        if (rst) begin
            cidx = '0; ctgl = 1'b0;
        end else if (cons_en && (bmem[cidx][31] != ctgl)) begin
            if (expq.size() == 0) begin
                check("R10 unexpected entry", bmem[cidx], 32'hFFFF_FFFF);
            end else begin
                check("R10 consumed order", {1'b0, bmem[cidx][30:0]}, {1'b0, expq.pop_front()});
            end
            cidx = cidx + 1'b1;
            if (cidx == '0) ctgl = ~ctgl;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send(input logic [30:0] n);
        ntf_num = n;
        ntf_valid = 1'b1;
        do @(posedge clk); while (!ntf_ready);
        #1 ntf_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [LOG2-1:0] saved;
        do_reset();
        @(negedge clk);
        check("R1 idx after reset", 32'(wr_idx), 32'd0);
        check("R1 gen after reset", {31'd0, wr_gen}, 32'd1);
        check("R1 no write after reset", {31'd0, mem_we}, 32'd0);
        check("R1 overflow after reset", {31'd0, overflow}, 32'd0);
        tick();

        // device notifications with the consumer idle
        send(31'd5);
        send(31'h7FFF_FFFF);
        send(31'd1);
        tick();
        saved = wr_idx;
        send(31'd0);
        tick(); tick();
        check("R5 zero leaves index", 32'(wr_idx), 32'(saved));
        check("R5 zero leaves overflow", {31'd0, overflow}, 32'd0);
        send(31'h00AB_CDEF);

        // IPI colliding with a device notification
        ipi_req = 1'b1; ntf_num = 31'd77; ntf_valid = 1'b1;
        @(negedge clk);
        check("R6 ready low during ipi", {31'd0, ntf_ready}, 32'd0);
        @(posedge clk); #1 ipi_req = 1'b0;
        @(negedge clk);
        check("R6 ipi entry number", {1'b0, mem_wdata[30:0]}, {1'b0, IPI_VAL});
        @(posedge clk); #1 ntf_valid = 1'b0;

        // fill and overrun the ring
        for (int k = 0; k < 5; k++) send(31'(100 + k));
        tick();
        @(negedge clk);
        check("R4 generation after first wrap", {31'd0, wr_gen}, 32'd0);
        check("R7 overflow after overrun", {31'd0, overflow}, 32'd1);
        check("R7 index held when full", 32'(wr_idx), 32'd0);
        for (int k = 0; k < 4; k++) tick();
        check("R8 overflow still set", {31'd0, overflow}, 32'd1);

        // drain, then stream through several wraps
        cons_en = 1'b1;
        for (int k = 0; k < 12; k++) tick();
        check("R10 ring drained", 32'(expq.size()), 32'd0);
        for (int k = 0; k < 30; k++) send(31'(1000 + 3 * k));
        for (int k = 0; k < 6; k++) tick();
        check("R10 stream drained", 32'(expq.size()), 32'd0);
        check("R8 overflow held through traffic", {31'd0, overflow}, 32'd1);

        // reset clears the sticky flag and the pointers
        do_reset();
        @(negedge clk);
        check("R1 overflow cleared by reset", {31'd0, overflow}, 32'd0);
        check("R1 idx after second reset", 32'(wr_idx), 32'd0);
        check("R1 gen after second reset", {31'd0, wr_gen}, 32'd1);
        tick();
        send(31'd9);
        tick(); tick(); tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule